// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block turns a fast input clock into a slower one. Software sets the division ratio through a divisor field and turns the output on and off with an enable bit. The block drives two outputs from flops: a divided clock, and a one-cycle clock-enable strobe that marks the first input cycle of every output period. Logic that must stay in the input clock domain uses the strobe. Logic that needs a real slow clock uses the divided clock.

A small phase state machine has three states. `PH_STOP` holds the output low and idle. `PH_HIGH` counts the high phase. `PH_LOW` counts the low phase. The transitions are:
- START goes from `PH_STOP` or the last cycle of `PH_LOW` into `PH_HIGH`. When the high phase has zero length it goes straight to `PH_LOW`.
- FALL goes from the last cycle of `PH_HIGH` to `PH_LOW`.
- HALT goes from `PH_STOP` or the last cycle of `PH_LOW` to `PH_STOP` while the enable bit is clear.
- COUNT stays in `PH_HIGH` or `PH_LOW` while the phase counter runs down.

A divisor that software writes is held as pending. It moves into the active divisor only at a period boundary, or at the next edge while the block is stopped. The busy flags stay set until that happens. A parameter selects a 5-bit divisor field or a 6-bit field. In the 6-bit field the top bit adds a fixed divide-by-64 prescale.

Top module: `clkdiv_gated`

## Requirements
- R1: After reset the divided clock and the strobe are low, and the divisor, enable and status registers all read 0.
- R2: With `DIV_W`=5, a divisor field f from 1 to 31 gives an output period of f input cycles. The value 0 gives 32.
- R3: With `DIV_W`=6 and bit 5 clear, the period is the low five bits, and 0 gives 64. With bit 5 set, the period is 64 times the low five bits, and a low part of 0 gives 64.
- R4: In each period of D cycles the output is high for floor(D/2) cycles first, then low for the rest. So the duty cycle is even for even D, and the high phase is one cycle shorter for odd D. With D=1 the output stays low.
- R5: The strobe is high for exactly the first input cycle of every running period. Every rising edge of the divided clock coincides with a strobe cycle.
- R6: Writing address 1 sets the enable bit from data bit 0. Reading address 1 returns it. When the block is stopped and the enable bit is set, a new period starts at the first edge after the write edge.
- R7: Clearing the enable bit lets the current period finish, both its high and low phases. After that the output stays low and no strobe is produced.
- R8: A new divisor takes effect at the next period boundary. While the block is stopped it takes effect at the next edge. A running period is never shortened.
- R9: A divisor write sets status bits 4 and 3 (read mask 0x18) at its edge. They clear at the edge where the divisor is loaded, unless another divisor write lands in that same edge. All other status bits read 0.
- R10: Address 0 is the divisor (low `DIV_W` bits, upper bits read 0), address 1 the enable, address 2 the status, and address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| clk_div_out | output | 1 | Divided, gated clock from a flop |
| clk_div_stb | output | 1 | One-cycle strobe at each period start |

## Verification
The bench builds two copies side by side from the same register stimulus. One uses `DIV_W`=5 and the other `DIV_W`=6. The 6-bit copy reaches the prescaled divisors, including the largest period of 1984 cycles and the aliasing of 0x20 to 64. The 5-bit copy sees the same writes masked. This shows the wrap-around of field values and the divide-by-1 and divide-by-32 ends of the range. Pending writes that land mid-period, disables in the high phase and back-to-back divisor writes are compared every cycle on both widths.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
    typedef enum logic [1:0] {
        PH_STOP = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    localparam logic [1:0] ADDR_DIV  = 2'd0;
    localparam logic [1:0] ADDR_EN   = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int BUSY_LO_BIT = 3;
    localparam int BUSY_HI_BIT = 4;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    output logic [DIV_W-1:0]  div_field,
    output logic              en,
    output logic              busy,
    output logic [DATA_W-1:0] rdata
);
    logic wr_div;
    logic wr_en;
    logic [DATA_W-1:0] status;
    logic unused_wdata;

    assign wr_div       = wr && (addr == ADDR_DIV);
    assign wr_en        = wr && (addr == ADDR_EN);
    assign unused_wdata = ^wdata[DATA_W-1:DIV_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_field <= '0;
            en        <= 1'b0;
            busy      <= 1'b0;
        end else begin
            if (wr_div) begin
                div_field <= wdata[DIV_W-1:0];
                busy      <= 1'b1;
            end else if (load) begin
                busy      <= 1'b0;
            end
            if (wr_en) begin
                en <= wdata[0];
            end
        end
    end

    always_comb begin
        status              = '0;
        status[BUSY_LO_BIT] = busy;
        status[BUSY_HI_BIT] = busy;
        unique case (addr)
            ADDR_DIV:  rdata = DATA_W'(div_field);
            ADDR_EN:   rdata = DATA_W'(en);
            ADDR_STAT: rdata = status;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkdiv_decode.sv
`timescale 1ns/1ps
module clkdiv_decode #(
    parameter int DIV_W = 5,
    parameter int CNT_W = 6
) (
    input  logic [DIV_W-1:0] field,
    output logic [CNT_W-1:0] hi_len,
    output logic [CNT_W-1:0] lo_len
);
    logic [CNT_W-1:0] eff;

    generate
        if (DIV_W == 6) begin : g_prescale
            logic [4:0] low5;
            assign low5 = field[4:0];
            always_comb begin
                if (low5 == 5'd0) begin
                    eff = CNT_W'(64);
                end else if (field[5]) begin
                    eff = CNT_W'({low5, 6'b0});
                end else begin
                    eff = CNT_W'(low5);
                end
            end
        end else begin : g_plain
            always_comb begin
                if (field == '0) begin
                    eff = CNT_W'(1 << DIV_W);
                end else begin
                    eff = CNT_W'(field);
                end
            end
        end
    endgenerate

    assign hi_len = eff >> 1;
    assign lo_len = eff - hi_len;
endmodule

// File: rtl/clkdiv_phase.sv
`timescale 1ns/1ps
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             busy,
    input  logic [DIV_W-1:0] div_field,
    output logic             load,
    output logic [DIV_W-1:0] act_div,
    output phase_e           phase,
    output logic             clk_out,
    output logic             stb
);
    phase_e           nphase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ncnt;
    logic             nstb;
    logic             at_edge;
    logic [DIV_W-1:0] sel_div;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;

    assign at_edge = (phase == PH_STOP) || ((phase == PH_LOW) && (cnt == '0));
    assign load    = at_edge && busy;
    assign sel_div = load ? div_field : act_div;

    clkdiv_decode #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_decode (
        .field  (sel_div),
        .hi_len (hi_len),
        .lo_len (lo_len)
    );

    always_comb begin
        nphase = phase;
        ncnt   = cnt;
        nstb   = 1'b0;
        unique case (phase)
            PH_STOP, PH_LOW: begin
                if ((phase == PH_LOW) && (cnt != '0)) begin
                    ncnt = cnt - CNT_W'(1);
                end else if (en) begin
                    nstb = 1'b1;
                    if (hi_len != '0) begin
                        nphase = PH_HIGH;
                        ncnt   = hi_len - CNT_W'(1);
                    end else begin
                        nphase = PH_LOW;
                        ncnt   = lo_len - CNT_W'(1);
                    end
                end else begin
                    nphase = PH_STOP;
                    ncnt   = '0;
                end
            end
            PH_HIGH: begin
                if (cnt == '0) begin
                    nphase = PH_LOW;
                    ncnt   = lo_len - CNT_W'(1);
                end else begin
                    ncnt = cnt - CNT_W'(1);
                end
            end
            default: begin
                nphase = PH_STOP;
                ncnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_STOP;
            cnt     <= '0;
            act_div <= '0;
        end else begin
            phase <= nphase;
            cnt   <= ncnt;
            if (load) begin
                act_div <= div_field;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_out <= 1'b0;
            stb     <= 1'b0;
        end else begin
            clk_out <= (nphase == PH_HIGH);
            stb     <= nstb;
        end
    end
endmodule

// File: rtl/clkdiv_gated.sv
`timescale 1ns/1ps
module clkdiv_gated
    import clkdiv_pkg::*;
#(
    parameter int DIV_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_div_out,
    output logic              clk_div_stb
);
    localparam int MAX_DIV = (DIV_W == 6) ? 31 * 64 : (1 << DIV_W);
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    logic [DIV_W-1:0] div_field;
    logic [DIV_W-1:0] act_div;
    logic             en;
    logic             busy;
    logic             load;
    phase_e           phase;

    clkdiv_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .load      (load),
        .div_field (div_field),
        .en        (en),
        .busy      (busy),
        .rdata     (reg_rdata)
    );

    clkdiv_phase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .busy      (busy),
        .div_field (div_field),
        .load      (load),
        .act_div   (act_div),
        .phase     (phase),
        .clk_out   (clk_div_out),
        .stb       (clk_div_stb)
    );
endmodule

// File: rtl/clkdiv_chk.sv
`timescale 1ns/1ps
module clkdiv_chk
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wbit,
    input logic             clk_div_out,
    input logic             clk_div_stb,
    input logic             busy,
    input logic             en,
    input logic             load,
    input logic [DIV_W-1:0] act_div,
    input phase_e           phase
);
    // R9
    busy_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DIV) |=> busy);

    // R9
    busy_clear_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(load));

    // R8
    div_change_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_div) |-> $past(load));

    // R5
    rise_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_div_out) |-> clk_div_stb);

    // R7
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP) |-> (!clk_div_out && !clk_div_stb));

    // R6
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EN) |=> (en == $past(wbit)));
endmodule

bind clkdiv_gated clkdiv_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wbit        (reg_wdata[0]),
    .clk_div_out (clk_div_out),
    .clk_div_stb (clk_div_stb),
    .busy        (busy),
    .en          (en),
    .load        (load),
    .act_div     (act_div),
    .phase       (phase)
);

// File: tb/clkdiv_gated_tb.sv
`timescale 1ns/1ps
module clkdiv_gated_tb;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd2;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] rdata_n, rdata_w;
    logic              out_n, out_w, stb_n, stb_w;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    clkdiv_gated #(.DIV_W(5), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
        .clk_div_out(out_n), .clk_div_stb(stb_n));

    clkdiv_gated #(.DIV_W(6), .DATA_W(DATA_W)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_w),
        .clk_div_out(out_w), .clk_div_stb(stb_w));

    // behavioural model, index 0: 5-bit field, index 1: 6-bit field
    int m_div[2], m_en[2], m_busy[2], m_act[2], m_run[2], m_pos[2];
    int m_out[2], m_stb[2];
    int wid[2] = '{5, 6};

    function automatic int period_of(int w, int f);
        int low;
        if (w == 6) begin
            low = f & 31;
            if (low == 0) return 64;
            if ((f & 32) != 0) return 64 * low;
            return low;
        end
        return (f == 0) ? 32 : f;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_div[k] = 0; m_en[k] = 0; m_busy[k] = 0; m_act[k] = 0;
                m_run[k] = 0; m_pos[k] = 0; m_out[k] = 0; m_stb[k] = 0;
            end else begin
                int d;
                int nb;
                d  = period_of(wid[k], m_act[k]);
                nb = m_busy[k];
                if (!m_run[k] || m_pos[k] == d - 1) begin
                    if (m_busy[k] != 0) begin
                        m_act[k] = m_div[k];
                        nb = 0;
                    end
                    m_pos[k] = 0;
                    m_run[k] = m_en[k];
                    m_stb[k] = m_en[k];
                end else begin
                    m_pos[k] = m_pos[k] + 1;
                    m_stb[k] = 0;
                end
                m_out[k] = (m_run[k] != 0 &&
                            m_pos[k] < period_of(wid[k], m_act[k]) / 2) ? 1 : 0;
                if (reg_wr && reg_addr == 2'd0) begin
                    m_div[k] = int'(reg_wdata) & ((1 << wid[k]) - 1);
                    nb = 1;
                end
                if (reg_wr && reg_addr == 2'd1) m_en[k] = int'(reg_wdata[0]);
                m_busy[k] = nb;
            end
        end
    end

    function automatic int model_rd(int k, int a);
        case (a)
            0: return m_div[k];
            1: return m_en[k];
            2: return (m_busy[k] != 0) ? 32'h18 : 0;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check(cur_tag, "out5", int'(out_n), m_out[0]);
            check(cur_tag, "stb5", int'(stb_n), m_stb[0]);
            check(cur_tag, "rd5", int'(rdata_n), model_rd(0, int'(reg_addr)));
            check(cur_tag, "out6", int'(out_w), m_out[1]);
            check(cur_tag, "stb6", int'(stb_w), m_stb[1]);
            check(cur_tag, "rd6", int'(rdata_w), model_rd(1, int'(reg_addr)));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        // R1: outputs and every register read as zero after reset
        cur_tag = "R1";
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            reg_addr = 2'(a);
            #1;
            check("R1", "reset rd5", int'(rdata_n), 0);
            check("R1", "reset rd6", int'(rdata_w), 0);
            check("R1", "reset out", int'(out_n | out_w | stb_n | stb_w), 0);
        end
        // R10: writes to status and unused address change nothing
        cur_tag = "R10";
        wr(2'd3, 8'hFF);
        wr(2'd2, 8'hFF);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk);
            reg_addr = 2'(a);
            #1;
            check("R10", "map rd5", int'(rdata_n), 0);
            check("R10", "map rd6", int'(rdata_w), 0);
        end
        wr(2'd0, 8'hE9);
        @(negedge clk); reg_addr = 2'd0; #1;
        check("R10", "div upper bits rd5", int'(rdata_n), 9);
        check("R10", "div upper bits rd6", int'(rdata_w), 41);
        wr(2'd0, 8'h00);
        idle(3);
        // R6: enable starts the output
        cur_tag = "R6";
        wr(2'd1, 8'h01);
        @(negedge clk); reg_addr = 2'd1; #1;
        check("R6", "enable read5", int'(rdata_n), 1);
        check("R6", "enable read6", int'(rdata_w), 1);
        // R2: default field gives the largest divisor
        cur_tag = "R2";
        idle(140);
        // R4: duty cycle for 1, 2 and odd divisors
        cur_tag = "R4";
        wr(2'd0, 8'd1); idle(20);
        cur_tag = "R5";
        wr(2'd0, 8'd2); idle(20);
        cur_tag = "R4";
        wr(2'd0, 8'd7); idle(40);
        cur_tag = "R2";
        wr(2'd0, 8'd5); idle(40);
        wr(2'd0, 8'd31); idle(80);
        // R9: busy visible, overwritten while pending
        cur_tag = "R9";
        wr(2'd0, 8'd9); idle(2);
        wr(2'd0, 8'd4); idle(40);
        wr(2'd0, 8'd10);
        wr(2'd0, 8'd12); idle(60);
        // R3: prescaled divisors on the wide field
        cur_tag = "R3";
        wr(2'd0, 8'h20); idle(200);
        wr(2'd0, 8'h23); idle(500);
        wr(2'd0, 8'h05); idle(80);
        wr(2'd0, 8'h3F); idle(4300);
        wr(2'd0, 8'h00); idle(200);
        // R7: disable inside a high phase, period completes
        cur_tag = "R7";
        wr(2'd0, 8'd6); idle(150);
        while (!out_n) @(negedge clk);
        wr(2'd1, 8'h00); idle(100);
        // R8: load while stopped, then restart
        cur_tag = "R8";
        wr(2'd0, 8'd3); idle(5);
        wr(2'd1, 8'h01); idle(30);
        wr(2'd0, 8'd8); idle(40);
        finish_run();
    end
endmodule